// File: doc/BRIEF.md
# Snooping Three-State Invalidate Cache Controller

This block keeps coherence for one direct-mapped cache in a small shared-bus multiprocessor. Each line is in one of three states: invalid (`LN_INV`), shared clean (`LN_SHD`) or modified exclusive (`LN_MOD`). The processor side issues reads, writes and flushes. A flush writes a dirty line back and drops it. To serve these, the controller arbitrates for the shared bus and issues read, read-exclusive, upgrade or write-back transactions.

The controller also watches every transaction that other caches put on the bus. All controllers see those transactions in the same order. A snooped read of a modified line makes the controller drive its data onto the bus and downgrade the line to shared. A snooped read-exclusive or upgrade removes the local copy. A snooped write-back has no effect.

The bus carries one transaction per granted cycle. Memory answers a read in the same cycle. Each line holds one data word.

The request sequencer has these states:
- `F_IDLE`: accepts a processor request, but only in a cycle with no snoop.
- `F_UPG`: requests the bus for an upgrade. It moves to `F_FILL` if the shared copy was lost while waiting.
- `F_EVICT`: writes a modified victim back. It moves to `F_FILL` after a miss, or to `F_RESP` after a flush.
- `F_FILL`: fetches the line with a read or a read-exclusive.
- `F_RESP`: pulses `cpu_done` and returns to `F_IDLE`.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_done`, `bus_req` and `snp_flush` are low, and the first read of any address issues a bus read.
- R2: A read miss requests the bus with command 1 (read) at the request address. It installs the line shared and returns the bus data. A later read of that address completes without bus traffic. `cpu_done` is a one-cycle pulse.
- R3: A write to a shared line issues command 3 (upgrade) and then holds the line modified. A further write to that line completes without bus traffic.
- R4: A write miss issues command 2 (read-exclusive) and installs the line modified with the written data.
- R5: A snooped command 2 or 3 whose address matches a valid line invalidates that line. The next read then misses and returns the current memory value.
- R6: A snooped command 1 on a modified line raises `snp_flush` in that cycle with the line data on `snp_data`, and leaves the line shared. A snooped command 2 on a modified line also flushes.
- R7: A snoop whose tag differs from the resident line, a snooped read of a shared line, and a snooped command 4 (write-back) raise no flush and leave the line unchanged.
- R8: A miss whose victim (same index = low address bits) is modified first issues command 4 (write-back) with the victim address and data, then the fill. A shared victim is dropped with no bus traffic.
- R9: Processor op 2 (flush): on a modified hit it writes the line back with command 4 and invalidates it. On a shared hit it invalidates silently. On a miss it completes with no bus traffic and leaves the resident line as it was. Processor ops are 0 read and 1 write.
- R10: While `bus_req` waits without `bus_gnt`, the request, command and address stay stable and the processor request does not complete.
- R11: A snoop in the same cycle as a processor request is applied first. The request is evaluated only in a later cycle, against the updated line state.
- R12: If a pending upgrade loses its shared copy to a snooped invalidation, the controller issues command 2 (read-exclusive) instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_op | input | 2 | 0 read, 1 write, 2 flush |
| cpu_addr | input | ADDR_W | Word address; low bits index the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the transaction happens in a cycle with both high |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data returned in the granted cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |
| snp_data | output | DATA_W | Data supplied on a flush |

## Verification
The hardest case to reach is an upgrade that loses its shared copy while waiting for the bus. It needs a withheld grant, a pending upgrade, and a snooped invalidation of the same address, all in the right order. The stimulus first makes the line shared through a read. It then turns the grant off, starts a write, and confirms upgrade on the bus. Next it injects one snooped upgrade to that address. After that it expects the command to change to read-exclusive before it releases the grant. The same-cycle collision of a snoop and a processor request is forced by driving both on one falling edge. The collision is observed through the bus read that the stalled request then has to issue.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHD = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_UPG  = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_FLUSH = 2'd2
    } cpu_op_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_UPG,
        F_EVICT,
        F_FILL,
        F_RESP
    } fsm_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_st_e          rd_st,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  line_st_e          wr_st,
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);
    line_st_e          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    logic [IDX_W-1:0] snp_idx;
    logic [TAG_W-1:0] snp_tag;
    logic             snp_hit, snp_rd, snp_kill;

    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
    assign snp_hit  = snp_valid && (st_q[snp_idx] != LN_INV) && (tag_q[snp_idx] == snp_tag);
    assign snp_rd   = (snp_cmd == BC_RD);
    assign snp_kill = (snp_cmd == BC_RDX) || (snp_cmd == BC_UPG);

    // dirty owner supplies data for any snooped fetch
    assign snp_flush = snp_hit && (st_q[snp_idx] == LN_MOD) && (snp_rd || snp_cmd == BC_RDX);
    assign snp_data  = dat_q[snp_idx];

    assign rd_st   = st_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = dat_q[rd_idx];

    // state array: the snoop update is written last so it wins on a shared index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
        end else begin
            if (wr_en) st_q[wr_idx] <= wr_st;
            if (snp_hit && snp_kill) begin
                st_q[snp_idx] <= LN_INV;
            end else if (snp_hit && snp_rd && st_q[snp_idx] == LN_MOD) begin
                st_q[snp_idx] <= LN_SHD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

    // R6: after supplying dirty data the line is no longer modified
    a_r6_flush_leaves_mod: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |=> st_q[$past(snp_idx)] != LN_MOD);

    // R5: a matching invalidating snoop leaves the line invalid
    a_r5_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && snp_kill) |=> st_q[$past(snp_idx)] == LN_INV);
endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  cpu_op_e           cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  line_st_e          rd_st,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output line_st_e          wr_st
);
    fsm_st_e st_q, st_d;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             hit, is_wr, is_fl;

    assign idx   = cpu_addr[IDX_W-1:0];
    assign tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign hit   = (rd_st != LN_INV) && (rd_tag == tag);
    assign is_wr = (cpu_op == OP_WR);
    assign is_fl = (cpu_op == OP_FLUSH);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d      = st_q;
        cpu_done  = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        wr_en     = 1'b0;
        wr_tag    = tag;
        wr_data   = rd_data;
        wr_st     = rd_st;
        unique case (st_q)
            F_IDLE: begin
                if (cpu_req && !snp_valid) begin
                    case (cpu_op)
                        OP_RD: begin
                            if (hit)                  st_d = F_RESP;
                            else if (rd_st == LN_MOD) st_d = F_EVICT;
                            else                      st_d = F_FILL;
                        end
                        OP_WR: begin
                            if (hit && rd_st == LN_MOD) begin
                                wr_en   = 1'b1;
                                wr_data = cpu_wdata;
                                st_d    = F_RESP;
                            end else if (hit) begin
                                st_d = F_UPG;
                            end else if (rd_st == LN_MOD) begin
                                st_d = F_EVICT;
                            end else begin
                                st_d = F_FILL;
                            end
                        end
                        OP_FLUSH: begin
                            if (hit && rd_st == LN_MOD) begin
                                st_d = F_EVICT;
                            end else begin
                                if (hit) begin
                                    wr_en = 1'b1;
                                    wr_st = LN_INV;
                                end
                                st_d = F_RESP;
                            end
                        end
                        default: st_d = F_RESP;
                    endcase
                end
            end
            F_UPG: begin
                if (!(hit && rd_st == LN_SHD)) begin
                    st_d = F_FILL;
                end else begin
                    bus_req = 1'b1;
                    bus_cmd = BC_UPG;
                    if (bus_gnt) begin
                        wr_en   = 1'b1;
                        wr_data = cpu_wdata;
                        wr_st   = LN_MOD;
                        st_d    = F_RESP;
                    end
                end
            end
            F_EVICT: begin
                if (rd_st == LN_MOD) begin
                    bus_req   = 1'b1;
                    bus_cmd   = BC_WB;
                    bus_addr  = {rd_tag, idx};
                    bus_wdata = rd_data;
                end
                if (rd_st != LN_MOD || bus_gnt) begin
                    wr_en  = 1'b1;
                    wr_tag = rd_tag;
                    wr_st  = LN_INV;
                    st_d   = is_fl ? F_RESP : F_FILL;
                end
            end
            F_FILL: begin
                bus_req = 1'b1;
                bus_cmd = is_wr ? BC_RDX : BC_RD;
                if (bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_data = is_wr ? cpu_wdata : bus_rdata;
                    wr_st   = is_wr ? LN_MOD : LN_SHD;
                    st_d    = F_RESP;
                end
            end
            F_RESP: begin
                cpu_done = 1'b1;
                st_d     = F_IDLE;
            end
            default: st_d = F_IDLE;
        endcase
    end

    // R10: an ungranted request is held unchanged unless a snoop alters the line
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> bus_req);

    a_r10_addr_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> ($stable(bus_addr) && $stable(bus_cmd)));

    // R11: a snoop cycle in idle cannot complete a processor request next cycle
    a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_IDLE && snp_valid) |=> !cpu_done);

    // R2: completion is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e          rd_st, wr_st;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;
    bus_cmd_e          cmd_w;

    assign bus_cmd = cmd_w;

    coh_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (cpu_addr[IDX_W-1:0]),
        .rd_st     (rd_st),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (cpu_addr[IDX_W-1:0]),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .wr_st     (wr_st),
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .snp_addr  (snp_addr),
        .snp_flush (snp_flush),
        .snp_data  (snp_data)
    );

    coh_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_op    (cpu_op_e'(cpu_op)),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_done  (cpu_done),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_cmd   (cmd_w),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .snp_valid (snp_valid),
        .rd_st     (rd_st),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .wr_st     (wr_st)
    );

    assign cpu_rdata = rd_data;
endmodule

// File: tb/coh_snoop_ctrl_test.sv
`timescale 1ns/1ps
module coh_snoop_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic [7:0] cpu_addr = 8'h00, cpu_wdata = 8'h00;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req, bus_gnt;
    logic [2:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       snp_valid = 1'b0;
    logic [2:0] snp_cmd = 3'd0;
    logic [7:0] snp_addr = 8'h00;
    logic       snp_flush;
    logic [7:0] snp_data;
    logic       gnt_en = 1'b1;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    coh_snoop_ctrl #(.ADDR_W(8), .DATA_W(8), .LINES(4)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_addr(snp_addr), .snp_flush(snp_flush), .snp_data(snp_data)
    );

    // memory and bus log model
    logic [7:0] mem [0:255];
    int         lg_n;
    logic [2:0] lg_cmd  [0:7];
    logic [7:0] lg_addr [0:7];
    logic [7:0] lg_data [0:7];

    assign bus_gnt   = bus_req & gnt_en;
    assign bus_rdata = mem[bus_addr];

    always @(posedge clk) begin
        if (rst_n && bus_req && bus_gnt) begin
            if (lg_n < 8) begin
                lg_cmd[lg_n]  = bus_cmd;
                lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_wdata;
            end
            lg_n = lg_n + 1;
            if (bus_cmd == 3'd4) mem[bus_addr] = bus_wdata;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cpu_do(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        int n;
        @(negedge clk);
        lg_n = 0;
        cpu_req = 1'b1; cpu_op = op; cpu_addr = a; cpu_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_done && n < 60);
        if (!cpu_done) chk(1'b0, "watchdog cpu request", 0, 1);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [2:0] c, input logic [7:0] a,
                         output logic fl, output logic [7:0] sd);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        fl = snp_flush;
        sd = snp_data;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 3'd0;
    endtask

    function automatic logic [7:0] init_val(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    task automatic t_reset();
        logic [7:0] rd;
        chk(cpu_done == 1'b0, "R1 cpu_done after reset", cpu_done, 0);
        chk(bus_req == 1'b0, "R1 bus_req after reset", bus_req, 0);
        chk(snp_flush == 1'b0, "R1 snp_flush after reset", snp_flush, 0);
        cpu_do(2'd0, 8'h31, 8'h00, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd1, "R1 first read goes to bus", lg_cmd[0], 1);
    endtask

    task automatic t_read_miss();
        logic [7:0] rd;
        cpu_do(2'd0, 8'h10, 8'h00, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd1 && lg_addr[0] == 8'h10, "R2 read miss command", lg_cmd[0], 1);
        chk(rd == init_val(8'h10), "R2 read miss data", rd, init_val(8'h10));
        cpu_do(2'd0, 8'h10, 8'h00, rd);
        chk(lg_n == 0, "R2 read hit no bus", lg_n, 0);
    endtask

    task automatic t_upgrade();
        logic [7:0] rd;
        cpu_do(2'd1, 8'h10, 8'h77, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd3 && lg_addr[0] == 8'h10, "R3 upgrade command", lg_cmd[0], 3);
        cpu_do(2'd1, 8'h10, 8'h79, rd);
        chk(lg_n == 0, "R3 write hit modified no bus", lg_n, 0);
        cpu_do(2'd0, 8'h10, 8'h00, rd);
        chk(rd == 8'h79, "R3 read back written data", rd, 8'h79);
    endtask

    task automatic t_snoop_rd();
        logic fl; logic [7:0] sd, rd;
        snoop(3'd1, 8'h10, fl, sd);
        chk(fl == 1'b1 && sd == 8'h79, "R6 flush on snooped read", sd, 8'h79);
        snoop(3'd1, 8'h10, fl, sd);
        chk(fl == 1'b0, "R7 no flush on shared read", fl, 0);
        cpu_do(2'd1, 8'h10, 8'h7A, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd3, "R6 line left shared", lg_cmd[0], 3);
        snoop(3'd2, 8'h10, fl, sd);
        chk(fl == 1'b1 && sd == 8'h7A, "R6 flush on snooped read-exclusive", sd, 8'h7A);
        cpu_do(2'd0, 8'h10, 8'h00, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd1, "R5 read-exclusive snoop invalidated", lg_cmd[0], 1);
    endtask

    task automatic t_invalidate_seq();
        logic fl; logic [7:0] sd, rd;
        cpu_do(2'd0, 8'h21, 8'h00, rd);
        chk(rd == init_val(8'h21), "R5 first read value", rd, init_val(8'h21));
        snoop(3'd3, 8'h21, fl, sd);
        chk(fl == 1'b0, "R5 upgrade snoop on shared no flush", fl, 0);
        mem[8'h21] = 8'h01;
        cpu_do(2'd0, 8'h21, 8'h00, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd1, "R5 reread misses", lg_n, 1);
        chk(rd == 8'h01, "R5 reread gets new value", rd, 1);
    endtask

    task automatic t_snoop_miss();
        logic fl; logic [7:0] sd, rd;
        cpu_do(2'd1, 8'h10, 8'h66, rd);
        snoop(3'd1, 8'h14, fl, sd);
        chk(fl == 1'b0, "R7 other tag no flush", fl, 0);
        snoop(3'd4, 8'h10, fl, sd);
        chk(fl == 1'b0, "R7 write-back snoop no flush", fl, 0);
        cpu_do(2'd1, 8'h10, 8'h67, rd);
        chk(lg_n == 0, "R7 line still modified", lg_n, 0);
    endtask

    task automatic t_evict();
        logic [7:0] rd;
        cpu_do(2'd0, 8'h14, 8'h00, rd);
        chk(lg_n == 2 && lg_cmd[0] == 3'd4 && lg_addr[0] == 8'h10 && lg_data[0] == 8'h67,
            "R8 dirty victim written back", lg_data[0], 8'h67);
        chk(lg_cmd[1] == 3'd1 && lg_addr[1] == 8'h14, "R8 fill after write-back", lg_cmd[1], 1);
        chk(rd == init_val(8'h14), "R8 fill data", rd, init_val(8'h14));
        cpu_do(2'd0, 8'h18, 8'h00, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd1, "R8 shared victim silent", lg_n, 1);
    endtask

    task automatic t_write_miss_flush();
        logic fl; logic [7:0] sd, rd;
        cpu_do(2'd1, 8'h23, 8'h9C, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd2 && lg_addr[0] == 8'h23, "R4 write miss read-exclusive", lg_cmd[0], 2);
        cpu_do(2'd2, 8'h23, 8'h00, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd4 && lg_data[0] == 8'h9C, "R9 R4 flush of modified line", lg_data[0], 8'h9C);
        cpu_do(2'd0, 8'h23, 8'h00, rd);
        chk(lg_n == 1 && rd == 8'h9C, "R9 flushed line invalid", rd, 8'h9C);
        snoop(3'd1, 8'h23, fl, sd);
        chk(fl == 1'b0, "R7 shared read snoop no flush", fl, 0);
        cpu_do(2'd2, 8'h33, 8'h00, rd);
        chk(lg_n == 0, "R9 flush miss no bus", lg_n, 0);
        cpu_do(2'd0, 8'h23, 8'h00, rd);
        chk(lg_n == 0, "R9 flush miss keeps resident line", lg_n, 0);
        cpu_do(2'd2, 8'h23, 8'h00, rd);
        chk(lg_n == 0, "R9 shared flush silent", lg_n, 0);
        cpu_do(2'd0, 8'h23, 8'h00, rd);
        chk(lg_n == 1 && lg_cmd[0] == 3'd1, "R9 shared flush invalidated", lg_n, 1);
    endtask

    task automatic t_grant_wait();
        int n;
        gnt_en = 1'b0;
        @(negedge clk);
        lg_n = 0;
        cpu_req = 1'b1; cpu_op = 2'd0; cpu_addr = 8'h2A;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(bus_req == 1'b1 && bus_cmd == 3'd1 && bus_addr == 8'h2A && cpu_done == 1'b0,
                "R10 request held without grant", bus_cmd, 1);
        end
        gnt_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_done && n < 60);
        chk(cpu_done && cpu_rdata == init_val(8'h2A), "R10 completes after grant", cpu_rdata, init_val(8'h2A));
        cpu_req = 1'b0;
    endtask

    task automatic t_priority();
        int n;
        @(negedge clk);
        lg_n = 0;
        cpu_req = 1'b1; cpu_op = 2'd0; cpu_addr = 8'h2A;
        snp_valid = 1'b1; snp_cmd = 3'd2; snp_addr = 8'h2A;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 3'd0;
        n = 0;
        while (!cpu_done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(lg_n == 1 && lg_cmd[0] == 3'd1, "R11 snoop applied before request", lg_n, 1);
        cpu_req = 1'b0;
    endtask

    task automatic t_lost_upgrade();
        int n;
        logic [7:0] rd;
        gnt_en = 1'b0;
        @(negedge clk);
        lg_n = 0;
        cpu_req = 1'b1; cpu_op = 2'd1; cpu_addr = 8'h2A; cpu_wdata = 8'h44;
        @(negedge clk);
        @(negedge clk);
        chk(bus_req == 1'b1 && bus_cmd == 3'd3, "R12 upgrade pending", bus_cmd, 3);
        snp_valid = 1'b1; snp_cmd = 3'd3; snp_addr = 8'h2A;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 3'd0;
        @(negedge clk);
        chk(bus_req == 1'b1 && bus_cmd == 3'd2, "R12 switched to read-exclusive", bus_cmd, 2);
        gnt_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_done && n < 60);
        chk(lg_n == 1 && lg_cmd[0] == 3'd2, "R12 granted read-exclusive", lg_cmd[0], 2);
        cpu_req = 1'b0;
        cpu_do(2'd0, 8'h2A, 8'h00, rd);
        chk(lg_n == 0 && rd == 8'h44, "R12 line modified with write data", rd, 8'h44);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        lg_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_upgrade();
        t_snoop_rd();
        t_invalidate_seq();
        t_snoop_miss();
        t_evict();
        t_write_miss_flush();
        t_grant_wait();
        t_priority();
        t_lost_upgrade();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(5.0 * 20000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule